// File: doc/BRIEF.md
# Resumable Vector Element Start Controller

This block owns the start-index register that tells a vector instruction which element to begin with, and it hands out element indices to the execution datapath one per cycle. Software reads and writes the register through a CSR port. Hardware clears it when an instruction finishes, and hardware loads it with the faulting element when a trap arrives. A trapped instruction can therefore be issued again and carry on from the element where it stopped. Destination elements below the start index are never presented, so the datapath leaves them undisturbed.

An instruction is offered on a valid/ready issue handshake. The handshake carries the active vector length, the largest element count for the current configuration, and a flag that says the instruction only runs from element zero. Issue is accepted only while no instruction is in flight, so `issue_ready` is low for the whole element walk. Elements leave on a valid/ready stream. While `elem_ready` is low, the index and last flag hold, and the walk advances only on a cycle where valid and ready are both high. Completion and illegal-instruction results are one-cycle pulses with no handshake.

When the start value is illegal, the instruction runs no elements and the register keeps its value. When the start value is at or past the vector length, the instruction completes at once and still clears the register.

Top module: `velem_start_ctrl`

## Requirements
- R1: After reset, `csr_rd_data` reads 0, no element is valid, `issue_ready` is 1, and `done` and `illegal` are 0.
- R2: A CSR write keeps only the low log2(VLEN) bits of the written data (data AND (VLEN-1)). The bits above that field always read back as zero.
- R3: A legal instruction with start value s < vl presents the indices s, s+1, ... vl-1, advancing by one per accepted element. `elem_last` is 1 only on index vl-1, and no index below s is ever presented.
- R4: While `elem_valid` is 1 and `elem_ready` is 0, the next cycle still has `elem_valid` at 1 and the same `elem_idx`.
- R5: One cycle after the last element is accepted, `done` pulses and the register reads 0.
- R6: A legal issue with s >= vl (this includes vl = 0) presents no element. `done` pulses in the next cycle and the register reads 0.
- R7: An issue with s >= vlmax raises `illegal` in the next cycle. It presents no element, gives no `done`, and leaves the register unchanged.
- R8: An issue with `issue_need_zero` = 1 and s != 0 is illegal in the same way as R7. With s = 0, the same instruction runs normally.
- R9: `trap_en` during an element walk ends the walk. The register then holds the index presented in that cycle, no `done` follows, and re-issuing resumes at that index. `trap_en` while idle has no effect.
- R10: Within a single cycle, trap capture takes priority over completion clear, and completion clear takes priority over a CSR write.
- R11: `issue_ready` is 0 while an element walk is in progress.
- R12: `done` and `illegal` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Software write strobe for the start register |
| csr_wr_data | input | XLEN | Software write data |
| csr_rd_data | output | XLEN | Start register value, zero-extended |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction accepted when valid is also high |
| issue_vl | input | log2(VLEN)+1 | Active vector length |
| issue_vlmax | input | log2(VLEN)+1 | Largest element count for the current configuration |
| issue_need_zero | input | 1 | Instruction requires a zero start index |
| elem_valid | output | 1 | Element index is presented |
| elem_ready | input | 1 | Datapath takes the presented element |
| elem_idx | output | log2(VLEN) | Element index |
| elem_last | output | 1 | Presented element is vl-1 |
| trap_en | input | 1 | Trap taken on the presented element |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
A corrupted start register shows up at the ports in two ways. The first shows up through `csr_rd_data` one cycle after the event that should have set it. The second shows up as a wrong first `elem_idx` on the next issue. A sequencer that skips or repeats an index fails the index comparison on the very cycle the bad value is presented. The bench tracks the expected register value across CSR writes, traps and completions. This catches a wrong priority in the cycle right after a collision, and it also catches it on the resumed instruction that follows.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {
    DEC_RUN     = 2'd0,
    DEC_SKIP    = 2'd1,
    DEC_ILLEGAL = 2'd2
  } issue_dec_e;
endpackage

// File: rtl/vsc_start_reg.sv
module vsc_start_reg #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr_en,
  input  logic [IDXW-1:0] csr_wr_idx,
  input  logic            clr_en,
  input  logic            trap_en,
  input  logic [IDXW-1:0] trap_idx,
  output logic [IDXW-1:0] start_q
);
  // trap over clear over software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         start_q <= '0;
    else if (trap_en)   start_q <= trap_idx;
    else if (clr_en)    start_q <= '0;
    else if (csr_wr_en) start_q <= csr_wr_idx;
  end

  AST_TRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> start_q == $past(trap_idx)); // R9
  AST_CLEAR_OVER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !trap_en |=> start_q == '0); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en && !clr_en && !csr_wr_en |=> $stable(start_q)); // R7
endmodule

// File: rtl/vsc_issue_check.sv
module vsc_issue_check
  import vsc_pkg::*;
#(
  parameter int IDXW = 8,
  localparam int VLW = IDXW + 1
) (
  input  logic [IDXW-1:0] start_idx,
  input  logic [VLW-1:0]  vl,
  input  logic [VLW-1:0]  vlmax,
  input  logic            need_zero,
  output issue_dec_e      dec
);
  logic [VLW-1:0] start_ext;
  assign start_ext = {1'b0, start_idx};

  always_comb begin
    if (start_ext >= vlmax || (need_zero && start_idx != '0)) dec = DEC_ILLEGAL;
    else if (start_ext >= vl)                                  dec = DEC_SKIP;
    else                                                       dec = DEC_RUN;
  end
endmodule

// File: rtl/vsc_elem_seq.sv
module vsc_elem_seq #(
  parameter int IDXW = 8,
  localparam int VLW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [IDXW-1:0] launch_idx,
  input  logic [VLW-1:0]  launch_vl,
  input  logic            abort,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IDXW-1:0] out_idx,
  output logic            out_last,
  output logic            finish
);
  logic            busy_q;
  logic [IDXW-1:0] idx_q;
  logic [VLW-1:0]  vl_q;

  assign out_valid = busy_q;
  assign out_idx   = idx_q;
  assign out_last  = busy_q && ({1'b0, idx_q} == vl_q - 1'b1);
  assign finish    = busy_q && out_ready && out_last && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      idx_q  <= launch_idx;
      vl_q   <= launch_vl;
    end else if (busy_q) begin
      if (abort || (out_ready && out_last)) busy_q <= 1'b0;
      else if (out_ready)                   idx_q  <= idx_q + 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !abort |=> out_valid && $stable(out_idx)); // R4
  AST_IDX_IN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> {1'b0, out_idx} < vl_q); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && !abort |=> out_valid && out_idx == $past(out_idx) + 1'b1); // R3
endmodule

// File: rtl/velem_start_ctrl.sv
module velem_start_ctrl
  import vsc_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(VLEN),
  localparam int VLW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr_en,
  input  logic [XLEN-1:0] csr_wr_data,
  output logic [XLEN-1:0] csr_rd_data,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [VLW-1:0]  issue_vl,
  input  logic [VLW-1:0]  issue_vlmax,
  input  logic            issue_need_zero,
  output logic            elem_valid,
  input  logic            elem_ready,
  output logic [IDXW-1:0] elem_idx,
  output logic            elem_last,
  input  logic            trap_en,
  output logic            done,
  output logic            illegal
);
  logic [IDXW-1:0] start_q;
  issue_dec_e      dec;
  logic            issue_fire, trap_take, seq_finish, clr_now;
  logic            unused_hi;

  assign unused_hi   = ^csr_wr_data[XLEN-1:IDXW];
  assign csr_rd_data = {{(XLEN-IDXW){1'b0}}, start_q};
  assign issue_ready = !elem_valid;
  assign issue_fire  = issue_valid && issue_ready;
  assign trap_take   = trap_en && elem_valid;
  assign clr_now     = seq_finish || (issue_fire && dec == DEC_SKIP);

  vsc_issue_check #(.IDXW(IDXW)) u_chk (
    .start_idx (start_q),
    .vl        (issue_vl),
    .vlmax     (issue_vlmax),
    .need_zero (issue_need_zero),
    .dec       (dec)
  );

  vsc_start_reg #(.IDXW(IDXW)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr_en  (csr_wr_en),
    .csr_wr_idx (csr_wr_data[IDXW-1:0]),
    .clr_en     (clr_now),
    .trap_en    (trap_take),
    .trap_idx   (elem_idx),
    .start_q    (start_q)
  );

  vsc_elem_seq #(.IDXW(IDXW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (issue_fire && dec == DEC_RUN),
    .launch_idx (start_q),
    .launch_vl  (issue_vl),
    .abort      (trap_take),
    .out_valid  (elem_valid),
    .out_ready  (elem_ready),
    .out_idx    (elem_idx),
    .out_last   (elem_last),
    .finish     (seq_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= clr_now;
      illegal <= issue_fire && dec == DEC_ILLEGAL;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal)); // R12
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> !issue_ready); // R11
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && dec == DEC_ILLEGAL && !csr_wr_en |=> !elem_valid && start_q == $past(start_q)); // R7
  AST_TRAP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !done); // R10
endmodule

// File: tb/velem_start_ctrl_tb.sv
`timescale 1ns/1ps
module velem_start_ctrl_tb;
  localparam int VLEN = 256;
  localparam int XLEN = 64;
  localparam int IDXW = $clog2(VLEN);
  localparam int VLW  = IDXW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_wr_en = 1'b0;
  logic [XLEN-1:0] csr_wr_data = '0, csr_rd_data;
  logic issue_valid = 1'b0, issue_ready, issue_need_zero = 1'b0;
  logic [VLW-1:0] issue_vl = '0, issue_vlmax = '0;
  logic elem_valid, elem_ready = 1'b0, elem_last, trap_en = 1'b0, done, illegal;
  logic [IDXW-1:0] elem_idx;

  int checks = 0, errors = 0, cycles = 0;
  int exp_start = 0;

  always #4 clk = ~clk;

  velem_start_ctrl #(.VLEN(VLEN), .XLEN(XLEN)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mask_idx(input logic [XLEN-1:0] d);
    return int'(d & XLEN'(VLEN - 1));
  endfunction

  // 0 run, 1 skip, 2 illegal
  function automatic int decide(input int s, input int vl, input int vlmax, input bit nz);
    if (s >= vlmax || (nz && s != 0)) return 2;
    if (s >= vl) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic csr_write(input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
    #1;
    exp_start = mask_idx(d);
    chk(csr_rd_data == XLEN'(exp_start), "R2 masked write", csr_rd_data, exp_start);
  endtask

  task automatic run_instr(input int vl, input int vlmax, input bit nz, input int trap_at,
                           input int pct, input bit collide);
    int kind, expi, n;
    bit rdy, tr;
    kind = decide(exp_start, vl, vlmax, nz);
    @(negedge clk);
    issue_valid = 1'b1; issue_vl = VLW'(vl); issue_vlmax = VLW'(vlmax); issue_need_zero = nz;
    #1;
    chk(issue_ready == 1'b1, "R11 idle ready", issue_ready, 1);
    @(negedge clk);
    issue_valid = 1'b0;
    #1;
    chk(!(done && illegal), "R12 exclusive pulses", {done, illegal}, 0);
    if (kind == 2) begin
      chk(illegal == 1'b1, nz ? "R8 need-zero illegal" : "R7 range illegal", illegal, 1);
      chk(elem_valid == 1'b0 && done == 1'b0, "R7 no run", {elem_valid, done}, 0);
      chk(csr_rd_data == XLEN'(exp_start), "R7 register kept", csr_rd_data, exp_start);
      return;
    end
    chk(illegal == 1'b0, "R8 legal issue", illegal, 0);
    if (kind == 1) begin
      chk(done == 1'b1 && elem_valid == 1'b0, "R6 skip done", {done, elem_valid}, 2);
      chk(csr_rd_data == 0, "R6 cleared", csr_rd_data, 0);
      exp_start = 0;
      return;
    end
    expi = exp_start;
    n = 0;
    forever begin
      chk(elem_valid == 1'b1, "R3 valid", elem_valid, 1);
      chk(int'(elem_idx) == expi, "R3 index", elem_idx, expi);
      chk(elem_last == (expi == vl - 1), "R3 last", elem_last, expi == vl - 1);
      chk(issue_ready == 1'b0 && done == 1'b0, "R11 busy", {issue_ready, done}, 0);
      rdy = (($urandom % 100) < pct);
      tr  = (n == trap_at);
      elem_ready = rdy; trap_en = tr;
      if (collide && (tr || (rdy && expi == vl - 1))) begin
        csr_wr_en = 1'b1; csr_wr_data = XLEN'(VLEN - 1);
      end
      @(negedge clk);
      elem_ready = 1'b0; trap_en = 1'b0; csr_wr_en = 1'b0;
      #1;
      if (tr) begin
        chk(elem_valid == 1'b0 && done == 1'b0, "R9 trap stops", {elem_valid, done}, 0);
        chk(csr_rd_data == XLEN'(expi), "R10 R9 trap index", csr_rd_data, expi);
        exp_start = expi;
        return;
      end
      if (rdy && expi == vl - 1) begin
        chk(done == 1'b1 && elem_valid == 1'b0, "R5 done pulse", {done, elem_valid}, 2);
        chk(csr_rd_data == 0, "R5 R10 clear over write", csr_rd_data, 0);
        exp_start = 0;
        return;
      end
      if (rdy) expi++;
      n++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(csr_rd_data == 0, "R1 reset value", csr_rd_data, 0);
    chk(elem_valid == 0 && done == 0 && illegal == 0, "R1 outputs idle", {elem_valid, done, illegal}, 0);
    chk(issue_ready == 1, "R1 ready", issue_ready, 1);

    csr_write(64'hFFFF_FFFF_FFFF_FF37);           // R2
    run_instr(100, 256, 0, -1, 60, 0);            // R3 R4 R5 from 55
    csr_write(64'd200);
    run_instr(100, 128, 0, -1, 100, 0);           // R7
    csr_write(64'd5);
    run_instr(50, 256, 1, -1, 100, 0);            // R8 illegal
    csr_write(64'd0);
    run_instr(10, 256, 1, -1, 100, 0);            // R8 runs
    csr_write(64'd50);
    run_instr(20, 64, 0, -1, 100, 0);             // R6
    csr_write(64'd3);
    run_instr(0, 16, 0, -1, 100, 0);              // R6 vl=0
    csr_write(64'd10);
    run_instr(40, 64, 0, 8, 70, 0);               // R9 trap mid-walk
    run_instr(40, 64, 0, -1, 70, 0);              // R9 resume at trapped index
    @(negedge clk); trap_en = 1'b1;               // R9 idle trap ignored
    @(negedge clk); trap_en = 1'b0; #1;
    chk(csr_rd_data == XLEN'(exp_start) && elem_valid == 0, "R9 idle trap ignored", csr_rd_data, exp_start);
    csr_write(64'd250);
    run_instr(256, 256, 0, 5, 100, 1);            // R10 trap on last + write
    run_instr(256, 256, 0, -1, 100, 1);           // R10 completion + write
    csr_write(64'd255);
    run_instr(256, 256, 0, -1, 40, 0);            // R3 top index

    for (int i = 0; i < 40; i++) begin
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0) csr_write(XLEN'($urandom % 64));
        else                   csr_write({32'($urandom), 32'($urandom)});
      end else begin
        int vlmax, vl;
        vlmax = 1 + ($urandom % VLEN);
        vl    = $urandom % (vlmax + 1);
        run_instr(vl, vlmax, ($urandom % 8) == 0,
                  ($urandom % 4 == 0) ? int'($urandom % 40) : -1,
                  50 + ($urandom % 51), $urandom % 2);
      end
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
  end
endmodule